// File: doc/BRIEF.md
# System Control Block with Reset-Cause Tracking

This block sits on an APB bus next to a processor. It watches two status lines from the processor: a software reset request and a lockup indication. On a rising software request, or on a lockup while the lockup-reset option is enabled, it drives a one-cycle system reset request pulse. In the same cycle it records the cause in a sticky reset-cause register. Software reads that register after the reset to learn why the reset happened, then clears each bit by writing a one to it.

The cause and option registers are cleared only by the power-on reset. The system reset the block requests does not clear them, so the cause is still readable afterwards. The top sixteen words of the register space form a read-only identification window with peripheral and component ID bytes. The bus interface never inserts wait states and never signals an error.

Top module: `sysctl_top`

## Requirements
- R1: After power-on reset, the option register (byte offset 0x00C) and the cause register (byte offset 0x010) read zero, and `sys_rst_req_o` is low.
- R2: When `cpu_rst_req_i` rises, `sys_rst_req_o` is high for exactly one cycle, starting on the clock edge that first samples the request high. Holding the request high does not produce another pulse.
- R3: The same event sets cause bit 0 (software request). The bit stays set while the request stays high and after it falls.
- R4: Writing a 1 to a cause bit clears it. Writing a 0 to a cause bit leaves it unchanged.
- R5: Option bit 0 is the lockup-reset enable and reads back what was written. Option bits above bit 0 read zero. Writing the option register never changes the cause register.
- R6: With the enable at 0, a high `cpu_lockup_i` produces no pulse and no cause bit. When `cpu_lockup_i` and the enable are first both high, the block issues one pulse and sets cause bit 1 (lockup). This also applies when the enable is set while lockup is already high.
- R7: ID words live at byte offsets 0xFC0 to 0xFFC, with the ID byte in bits 7:0 and bits 31:8 reading zero. 0xFC0 to 0xFCC read 0. 0xFD0 reads 0x04. 0xFE0 reads the part number (default 0x26, always within 0x26..0x29). 0xFE4 reads 0xB8. 0xFE8 reads 0x0B. 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.
- R8: Writes to the ID window or to unmapped offsets change nothing. Unmapped offsets read zero. `pready` is always 1 and `pslverr` is always 0.
- R9: If a cause bit is cleared by a write in the same cycle that the event setting it occurs, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (12) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| cpu_rst_req_i | input | 1 | Processor software reset request |
| cpu_lockup_i | input | 1 | Processor lockup status |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Two functions can meet on one clock edge: a write-one-to-clear on the cause register, and a new reset event that sets the same bit. The bench sets up this collision by raising the software request in the same low phase that starts the access phase of a cause-clear write. The clearing edge and the setting edge are then the same edge. The result is judged by reading the cause register afterwards: the bit that was being set must read 1, and the other bit in the same clear mask must read 0. A second overlap comes from enabling lockup reset while lockup is already high, where a register write alone has to produce exactly one pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // cause register bit positions (software reads them)
  localparam int unsigned CAUSE_W      = 2;
  localparam int unsigned CAUSE_SW_BIT = 0;
  localparam int unsigned CAUSE_LK_BIT = 1;

  // number of words in the identification window
  localparam int unsigned ID_WORDS = 16;
  localparam int unsigned ID_IDX_W = $clog2(ID_WORDS);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_OPT,
    SEL_CAUSE,
    SEL_ID
  } reg_sel_e;

  // Sticky update: new events win over a simultaneous clear.
  function automatic logic [CAUSE_W-1:0] cause_next(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] set,
    input logic [CAUSE_W-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  // Identification byte for word index within the window.
  function automatic logic [7:0] id_byte(
    input logic [ID_IDX_W-1:0] idx,
    input logic [7:0]          part,
    input logic [3:0]          rev
  );
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h04;
      4'd8:    b = part;
      4'd9:    b = 8'hB8;
      4'd10:   b = {rev, 4'hB};
      4'd12:   b = 8'h0D;
      4'd13:   b = 8'hF0;
      4'd14:   b = 8'h05;
      4'd15:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sysctl_apb_if.sv
module sysctl_apb_if
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] OPT_OFS   = 12'h00C,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 12'h010
) (
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  output reg_sel_e            sel_o,
  output logic [ID_IDX_W-1:0] id_idx_o,
  output logic                wr_en_o,
  output logic                rd_en_o
);

  localparam int unsigned TAG_W = ADDR_W - ID_IDX_W - 2;

  logic in_id;

  assign in_id    = (paddr[ADDR_W-1 -: TAG_W] == {TAG_W{1'b1}}) &&
                    (paddr[1:0] == 2'b00);
  assign id_idx_o = paddr[ID_IDX_W+1:2];

  always_comb begin
    if (paddr == OPT_OFS)        sel_o = SEL_OPT;
    else if (paddr == CAUSE_OFS) sel_o = SEL_CAUSE;
    else if (in_id)              sel_o = SEL_ID;
    else                         sel_o = SEL_NONE;
  end

  assign wr_en_o = psel & penable & pwrite;
  assign rd_en_o = psel & ~pwrite;

endmodule

// File: rtl/sysctl_reset_track.sv
module sysctl_reset_track
  import sysctl_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               sw_req_i,
  input  logic               lockup_i,
  input  logic               lk_en_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               pulse_o,
  output logic               sw_trig_o,
  output logic               lk_trig_o
);

  logic               sw_q;
  logic               lk_q;
  logic               lk_qual;
  logic [CAUSE_W-1:0] set_vec;

  assign lk_qual   = lockup_i & lk_en_i;
  assign sw_trig_o = sw_req_i & ~sw_q;
  assign lk_trig_o = lk_qual & ~lk_q;

  always_comb begin
    set_vec               = '0;
    set_vec[CAUSE_SW_BIT] = sw_trig_o;
    set_vec[CAUSE_LK_BIT] = lk_trig_o;
  end

  // all state on power-on reset only, so it survives the reset it requests
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sw_q    <= 1'b0;
      lk_q    <= 1'b0;
      pulse_o <= 1'b0;
      cause_o <= '0;
    end else begin
      sw_q    <= sw_req_i;
      lk_q    <= lk_qual;
      pulse_o <= sw_trig_o | lk_trig_o;
      cause_o <= cause_next(cause_o, set_vec, clr_i);
    end
  end

endmodule

// File: rtl/sysctl_id_rom.sv
module sysctl_id_rom
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [7:0]  PART   = 8'h26,
  parameter logic [3:0]  REV    = 4'h0
) (
  input  logic [ID_IDX_W-1:0] idx_i,
  output logic [DATA_W-1:0]   word_o
);

  logic [DATA_W-1:0] rom [ID_WORDS];

  for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
    assign rom[g] = {{(DATA_W-8){1'b0}}, id_byte(ID_IDX_W'(g), PART, REV)};
  end

  assign word_o = rom[idx_i];

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OPT_OFS   = 12'h00C,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 12'h010,
  parameter logic [7:0]  PART      = 8'h26,
  parameter logic [3:0]  REV       = 4'h0
) (
  input  logic              pclk,
  input  logic              por_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              cpu_rst_req_i,
  input  logic              cpu_lockup_i,
  output logic              sys_rst_req_o
);

  reg_sel_e              sel_w;
  logic [ID_IDX_W-1:0]   id_idx_w;
  logic                  wr_en_w;
  logic                  rd_en_w;
  logic                  opt_wr_w;
  logic [CAUSE_W-1:0]    clr_w;
  logic [CAUSE_W-1:0]    cause_w;
  logic                  lk_en_q;
  logic                  sw_trig_w;
  logic                  lk_trig_w;
  logic [DATA_W-1:0]     id_word_w;

  sysctl_apb_if #(
    .ADDR_W   (ADDR_W),
    .OPT_OFS  (OPT_OFS),
    .CAUSE_OFS(CAUSE_OFS)
  ) u_if (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .sel_o   (sel_w),
    .id_idx_o(id_idx_w),
    .wr_en_o (wr_en_w),
    .rd_en_o (rd_en_w)
  );

  assign opt_wr_w = wr_en_w && (sel_w == SEL_OPT);
  assign clr_w    = (wr_en_w && (sel_w == SEL_CAUSE)) ? pwdata[CAUSE_W-1:0] : '0;

  always_ff @(posedge pclk or negedge por_n) begin
    if (!por_n)        lk_en_q <= 1'b0;
    else if (opt_wr_w) lk_en_q <= pwdata[0];
  end

  sysctl_reset_track u_track (
    .clk      (pclk),
    .por_n    (por_n),
    .sw_req_i (cpu_rst_req_i),
    .lockup_i (cpu_lockup_i),
    .lk_en_i  (lk_en_q),
    .clr_i    (clr_w),
    .cause_o  (cause_w),
    .pulse_o  (sys_rst_req_o),
    .sw_trig_o(sw_trig_w),
    .lk_trig_o(lk_trig_w)
  );

  sysctl_id_rom #(
    .DATA_W(DATA_W),
    .PART  (PART),
    .REV   (REV)
  ) u_id (
    .idx_i (id_idx_w),
    .word_o(id_word_w)
  );

  always_comb begin
    prdata = '0;
    if (rd_en_w) begin
      case (sel_w)
        SEL_OPT:   prdata = {{(DATA_W-1){1'b0}}, lk_en_q};
        SEL_CAUSE: prdata = {{(DATA_W-CAUSE_W){1'b0}}, cause_w};
        SEL_ID:    prdata = id_word_w;
        default:   prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk
  import sysctl_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic               pready,
  input logic               pslverr,
  input logic               sw_trig,
  input logic               lk_trig,
  input logic               lk_en,
  input logic               opt_wr,
  input logic [CAUSE_W-1:0] clr,
  input logic [CAUSE_W-1:0] cause,
  input logic               pulse
);

  // R2: every trigger produces the pulse, and the pulse is a single cycle
  p_trig_pulse_r2: assert property (@(posedge clk) disable iff (!por_n)
    (sw_trig || lk_trig) |=> pulse);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!por_n)
    pulse |=> !pulse);

  // R3: software event makes the cause bit set
  p_sw_cause_r3: assert property (@(posedge clk) disable iff (!por_n)
    sw_trig |=> cause[CAUSE_SW_BIT]);

  // R4: a one-write clears the bit when no event competes
  p_w1c_r4: assert property (@(posedge clk) disable iff (!por_n)
    (clr[CAUSE_SW_BIT] && !sw_trig) |=> !cause[CAUSE_SW_BIT]);

  // R5: enable only moves on an option write
  p_opt_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
    !opt_wr |=> $stable(lk_en));

  // R6: no enable, no software event -> no pulse; lockup event sets its bit
  p_no_lk_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!lk_en && !sw_trig) |=> !pulse);
  p_lk_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
    lk_trig |=> cause[CAUSE_LK_BIT]);

  // R8: bus never stalls or errors
  p_bus_ok_r8: assert property (@(posedge clk) disable iff (!por_n)
    pready && !pslverr);

  // R9: a set collides with a clear -> set wins
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!por_n)
    (sw_trig && clr[CAUSE_SW_BIT]) |=> cause[CAUSE_SW_BIT]);

endmodule

bind sysctl_top sysctl_chk u_chk (
  .clk    (pclk),
  .por_n  (por_n),
  .pready (pready),
  .pslverr(pslverr),
  .sw_trig(sw_trig_w),
  .lk_trig(lk_trig_w),
  .lk_en  (lk_en_q),
  .opt_wr (opt_wr_w),
  .clr    (clr_w),
  .cause  (cause_w),
  .pulse  (sys_rst_req_o)
);

// File: tb/tb_sysctl_top.sv
module tb_sysctl_top;

  logic        pclk = 1'b0;
  logic        por_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        cpu_rst_req_i = 1'b0;
  logic        cpu_lockup_i = 1'b0;
  logic        sys_rst_req_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] last_rd;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        rd_ev;

  localparam logic [11:0] A_OPT   = 12'h00C;
  localparam logic [11:0] A_CAUSE = 12'h010;

  always #2.5 pclk = ~pclk;

  sysctl_top dut (
    .pclk(pclk), .por_n(por_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .cpu_rst_req_i(cpu_rst_req_i),
    .cpu_lockup_i(cpu_lockup_i), .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares against the bus in access phase
  initial begin
    forever begin
      @(rd_ev);
      last_rd = prdata;
      check(prdata == exp_q[0], tag_q[0], prdata, exp_q[0]);
      check(pready && !pslverr, "R8 bus response", {30'h0, pready, pslverr}, 32'h2);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1 -> rd_ev;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d, input bit raise_sw);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    if (raise_sw) cpu_rst_req_i = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic count_pulses(input int n, input int e, input string tag);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge pclk);
      if (sys_rst_req_o) c++;
    end
    check(c == e, tag, 32'(c), 32'(e));
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    por_n = 1'b1;
    check(sys_rst_req_o == 1'b0, "R1 pulse low after reset", {31'h0, sys_rst_req_o}, 32'h0);
    apb_rd(A_OPT, 32'h0, "R1 option reset");
    apb_rd(A_CAUSE, 32'h0, "R1 cause reset");

    // option readback, no cause side effect
    apb_wr(A_OPT, 32'hFFFF_FFFF, 1'b0);
    apb_rd(A_OPT, 32'h1, "R5 option readback one");
    apb_rd(A_CAUSE, 32'h0, "R5 option write sets no cause");
    apb_wr(A_OPT, 32'h0, 1'b0);
    apb_rd(A_OPT, 32'h0, "R5 option readback zero");

    // software request
    @(negedge pclk); cpu_rst_req_i = 1'b1;
    count_pulses(4, 1, "R2 one pulse on request");
    count_pulses(4, 0, "R2 no retrigger while held");
    apb_rd(A_CAUSE, 32'h1, "R3 software cause while held");
    @(negedge pclk); cpu_rst_req_i = 1'b0;
    apb_rd(A_CAUSE, 32'h1, "R3 software cause after release");

    // write one to clear
    apb_wr(A_CAUSE, 32'h0, 1'b0);
    apb_rd(A_CAUSE, 32'h1, "R4 zero write no effect");
    apb_wr(A_CAUSE, 32'h1, 1'b0);
    apb_rd(A_CAUSE, 32'h0, "R4 one write clears");

    // lockup without enable
    @(negedge pclk); cpu_lockup_i = 1'b1;
    count_pulses(4, 0, "R6 no pulse when disabled");
    apb_rd(A_CAUSE, 32'h0, "R6 no cause when disabled");
    // enable while lockup already high
    apb_wr(A_OPT, 32'h1, 1'b0);
    count_pulses(4, 1, "R6 pulse on enable during lockup");
    apb_rd(A_CAUSE, 32'h2, "R6 lockup cause");
    @(negedge pclk); cpu_lockup_i = 1'b0;
    apb_wr(A_OPT, 32'h0, 1'b0);

    // clear collides with a new software event
    apb_wr(A_CAUSE, 32'h3, 1'b1);
    apb_rd(A_CAUSE, 32'h1, "R9 set wins over clear");
    @(negedge pclk); cpu_rst_req_i = 1'b0;

    // identification window
    apb_rd(12'hFC0, 32'h00, "R7 id word 0xFC0");
    apb_rd(12'hFD0, 32'h04, "R7 id word 0xFD0");
    apb_rd(12'hFE0, 32'h26, "R7 part number");
    check(last_rd >= 32'h26 && last_rd <= 32'h29, "R7 part number range", last_rd, 32'h26);
    apb_rd(12'hFE4, 32'hB8, "R7 id word 0xFE4");
    apb_rd(12'hFE8, 32'h0B, "R7 id word 0xFE8");
    apb_rd(12'hFF0, 32'h0D, "R7 id word 0xFF0");
    apb_rd(12'hFF4, 32'hF0, "R7 id word 0xFF4");
    apb_rd(12'hFF8, 32'h05, "R7 id word 0xFF8");
    apb_rd(12'hFFC, 32'hB1, "R7 id word 0xFFC");

    // ignored writes, unmapped reads
    apb_wr(12'hFE0, 32'hFFFF_FFFF, 1'b0);
    apb_rd(12'hFE0, 32'h26, "R8 id write ignored");
    apb_wr(12'h100, 32'hFFFF_FFFF, 1'b0);
    apb_rd(A_OPT, 32'h0, "R8 unmapped write leaves option");
    apb_rd(A_CAUSE, 32'h1, "R8 unmapped write leaves cause");
    apb_rd(12'h100, 32'h0, "R8 unmapped read zero");

    repeat (3) @(negedge pclk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule